// File: doc/BRIEF.md
# Fault-Checking Base-Extension Quotient Accumulator

During a residue-number base extension, one correction must be applied to every output channel for each whole unit in the sum of ξ_i/m_i over the source channels. This block computes that count one term at a time. Each incoming r-bit ξ_i comes with the index of its source modulus. The block adds an underestimate of ξ_i/m_i to a wide fixed-point fraction. The estimate is a truncated series in the small offset d_i = 2^R − m_i: one multiplier per higher-order term, each fed by a per-modulus constant table. Whenever the running sum reaches 1.0, the block pulses a one-bit correction two cycles after the term appeared and keeps only the fraction.

The fraction starts at a small bias just below the check window. If the computation is fault-free and the operand is in range, the fraction left at the end of an extension stays inside that bias. A start can request a check. When it does, the block inspects the leftover fraction once the term marked last has been added, and raises a sticky fault flag if any bit of the check window is set.

Control is a two-state machine. ST_IDLE ignores the bus. ST_RUN accumulates. Three transitions connect them. T_START (ST_IDLE to ST_RUN on start) and T_RESTART (ST_RUN to ST_RUN on start) both reload the fraction. T_FINISH (ST_RUN to ST_IDLE) fires once the last term has been added.

Top module: `basex_fault_acc`

## Requirements
- R1: After reset, corr and fault are 0 and the block is idle.
- R2: The fraction has F = SIGMA + R + clog2(N) + 2 bits. The modulus index i selects the offset d_i = 2i+1, so the modulus is 2^R − d_i. The added term is ξ·2^(F−R) + Σ_{j=1..S−1} floor(ξ·d_i^j·2^(F−R(j+1))), with one multiplier per j whose table constant is d_i^j.
- R3: A start loads the fraction with 2^(F−SIGMA−1), clears fault, latches check_en and enters ST_RUN, from either state.
- R4: A valid term on the bus in cycle c while running, with no start in cycle c+1, gives corr = 1 in cycle c+2 exactly when fraction + term ≥ 1.0. Only the low F bits are kept. In every other cycle corr is 0.
- R5: After the term flagged by xi_last has been added, the block returns to idle. Valid terms seen while idle produce no corr and leave fault unchanged.
- R6: If the check was requested, fault rises in the cycle of the last term's corr when any of fraction bits F−1 down to F−SIGMA is 1 after that term's addition.
- R7: If the start did not request the check, fault stays 0 for that extension.
- R8: Once high, fault stays high until the next start.
- R9: A start in the cycle in which a pending term would be added discards that term: corr is 0 in that cycle's successor and the fraction is reloaded.
- R10: corr and fault can both assert in the same cycle, for the same last term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a base extension and reload the fraction |
| check_en | input | 1 | Request the end-of-extension fault check, sampled with start |
| xi_valid | input | 1 | A term is on the bus |
| xi_last | input | 1 | The term on the bus ends the extension |
| xi | input | R | Channel value ξ_i |
| mod_idx | input | clog2(N) | Index of the source modulus, selects table constants |
| corr | output | 1 | Correction pulse: the sum crossed 1.0 |
| fault | output | 1 | Sticky fault flag |

## Verification
The correction pulse and the fault flag come from the same addition, so both fire in one cycle when a single last term drives the sum past 1.0 and also leaves residue in the check window. The bench provokes this with a maximal ξ on the largest offset and expects both outputs high together. It repeats the same term with the check off and expects the pulse alone. A second collision, start arriving in the very cycle a pending term would be added, is provoked directly and expected to suppress that pulse. A behavioural model, run every cycle against random starts, terms and last flags, judges all remaining overlaps.

// File: rtl/fdacc_pkg.sv
package fdacc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1
    } fdacc_state_e;

    // offset of modulus k below 2^R
    function automatic int unsigned mod_offset(input int k);
        return 2 * k + 1;
    endfunction

    function automatic logic [127:0] int_pow(input int unsigned base, input int e);
        logic [127:0] acc;
        acc = 128'd1;
        for (int q = 0; q < e; q++) begin
            acc = acc * 128'(base);
        end
        return acc;
    endfunction

endpackage

// File: rtl/fdacc_rom.sv
module fdacc_rom
    import fdacc_pkg::*;
#(
    parameter int N  = 16,
    parameter int RE = 8,
    parameter int S  = 2,
    parameter int IW = 4,
    parameter int NM = 1,
    parameter int CW = 8
) (
    input  logic [IW-1:0]         idx,
    output logic [NM-1:0][CW-1:0] cvec
);

    logic [N-1:0][NM-1:0][CW-1:0] tbl;

    generate
        for (genvar k = 0; k < N; k++) begin : g_mod
            for (genvar j = 1; j <= NM; j++) begin : g_ord
                if (S > 1) begin : g_used
                    localparam logic [127:0] VAL = int_pow(mod_offset(k), j);
                    assign tbl[k][j-1] = VAL[CW-1:0];
                end else begin : g_none
                    assign tbl[k][j-1] = '0;
                end
            end
        end
    endgenerate

    always_comb begin
        cvec = '0;
        for (int k = 0; k < N; k++) begin
            if (idx == IW'(k)) begin
                cvec = tbl[k];
            end
        end
    end

endmodule

// File: rtl/fdacc_mul.sv
module fdacc_mul #(
    parameter int R  = 36,
    parameter int S  = 2,
    parameter int NM = 1,
    parameter int CW = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_last,
    input  logic [R-1:0]                  in_xi,
    input  logic [NM-1:0][CW-1:0]         cvec,
    output logic                          s1_valid,
    output logic                          s1_last,
    output logic [R-1:0]                  s1_xi,
    output logic [NM-1:0][R+CW-1:0]       s1_prod
);

    localparam int PW = R + CW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_last  <= 1'b0;
            s1_xi    <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_last  <= in_last;
            s1_xi    <= in_xi;
        end
    end

    generate
        for (genvar j = 0; j < NM; j++) begin : g_mul
            if (S > 1) begin : g_used
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        s1_prod[j] <= '0;
                    end else begin
                        s1_prod[j] <= PW'(in_xi) * PW'(cvec[j]);
                    end
                end
            end else begin : g_none
                assign s1_prod[j] = '0;
            end
        end
    endgenerate

endmodule

// File: rtl/fdacc_term.sv
module fdacc_term #(
    parameter int R  = 36,
    parameter int S  = 2,
    parameter int NM = 1,
    parameter int CW = 8,
    parameter int FW = 93
) (
    input  logic [R-1:0]            xi,
    input  logic [NM-1:0][R+CW-1:0] prod,
    output logic [FW+1:0]           term
);

    localparam int PW = R + CW;
    localparam int TW = PW + FW + 2;

    logic [NM:0][FW+1:0] part;

    assign part[0] = (FW+2)'(xi) << (FW - R);

    generate
        for (genvar j = 1; j <= NM; j++) begin : g_part
            if (S > 1) begin : g_used
                localparam int SH = FW - R * (j + 1);
                logic [TW-1:0] wide;
                assign wide = TW'(prod[j-1]);
                if (SH >= 0) begin : g_left
                    assign part[j] = (FW+2)'(wide << SH);
                end else begin : g_right
                    assign part[j] = (FW+2)'(wide >> (-SH));
                end
            end else begin : g_none
                assign part[j] = '0;
            end
        end
    endgenerate

    always_comb begin
        term = '0;
        for (int k = 0; k <= NM; k++) begin
            term = term + part[k];
        end
    end

endmodule

// File: rtl/basex_fault_acc.sv
module basex_fault_acc
    import fdacc_pkg::*;
#(
    parameter int R     = 36,
    parameter int RE    = 8,
    parameter int S     = 2,
    parameter int SIGMA = 51,
    parameter int N     = 16,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          check_en,
    input  logic          xi_valid,
    input  logic          xi_last,
    input  logic [R-1:0]  xi,
    input  logic [IW-1:0] mod_idx,
    output logic          corr,
    output logic          fault
);

    localparam int FW = SIGMA + R + IW + 2;
    localparam int NM = (S > 1) ? S - 1 : 1;
    localparam int CW = RE * NM;
    localparam logic [FW-1:0] INIT = FW'(1) << (FW - SIGMA - 1);

    fdacc_state_e state_q, state_d;

    logic [NM-1:0][CW-1:0]   cvec;
    logic                    s1_valid, s1_last;
    logic [R-1:0]            s1_xi;
    logic [NM-1:0][R+CW-1:0] s1_prod;
    logic [FW+1:0]           term;
    logic [FW+1:0]           sum;
    logic [FW-1:0]           acc_q;
    logic                    chk_q, corr_q, fault_q;
    logic                    add_en, bad_frac;

    fdacc_rom #(.N(N), .RE(RE), .S(S), .IW(IW), .NM(NM), .CW(CW)) u_rom (
        .idx  (mod_idx),
        .cvec (cvec)
    );

    fdacc_mul #(.R(R), .S(S), .NM(NM), .CW(CW)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (xi_valid),
        .in_last  (xi_last),
        .in_xi    (xi),
        .cvec     (cvec),
        .s1_valid (s1_valid),
        .s1_last  (s1_last),
        .s1_xi    (s1_xi),
        .s1_prod  (s1_prod)
    );

    fdacc_term #(.R(R), .S(S), .NM(NM), .CW(CW), .FW(FW)) u_term (
        .xi   (s1_xi),
        .prod (s1_prod),
        .term (term)
    );

    assign add_en   = (state_q == ST_RUN) && !start && s1_valid;
    assign sum      = {2'b00, acc_q} + term;
    assign bad_frac = |sum[FW-1 -: SIGMA];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_START, T_RESTART, T_FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (start)                      state_d = ST_RUN;
                else if (s1_valid && s1_last)   state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            chk_q   <= 1'b0;
            corr_q  <= 1'b0;
            fault_q <= 1'b0;
        end else if (start) begin
            acc_q   <= INIT;
            chk_q   <= check_en;
            corr_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            corr_q <= add_en && (|sum[FW+1:FW]);
            if (add_en) begin
                acc_q <= sum[FW-1:0];
                if (s1_last && chk_q && bad_frac) begin
                    fault_q <= 1'b1;
                end
            end
        end
    end

    assign corr  = corr_q;
    assign fault = fault_q;

endmodule

// File: rtl/fdacc_chk.sv
module fdacc_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic xi_valid,
    input logic xi_last,
    input logic run,
    input logic corr,
    input logic fault
);

    AST_CORR_AFTER_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        corr |-> $past(xi_valid, 2)); // R4

    AST_CORR_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        corr |-> ($past(run) && !$past(start))); // R9

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !start) |=> fault); // R8

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !fault); // R3

    AST_FAULT_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(xi_valid && xi_last, 2)); // R6

endmodule

bind basex_fault_acc fdacc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .xi_valid (xi_valid),
    .xi_last  (xi_last),
    .run      (state_q == fdacc_pkg::ST_RUN),
    .corr     (corr),
    .fault    (fault)
);

// File: tb/sim_basex_fault_acc.sv
`timescale 1ns/1ps
module sim_basex_fault_acc;

    localparam int R = 36, SIGMA = 51, N = 16, IW = 4;
    localparam int FW = SIGMA + R + IW + 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, check_en = 0, xi_valid = 0, xi_last = 0;
    logic [R-1:0] xi = '0;
    logic [IW-1:0] mod_idx = '0;
    logic corr, fault;

    int n_chk = 0, n_fail = 0;
    bit model_on = 0;

    always #2.5 clk = ~clk;

    basex_fault_acc u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .check_en(check_en),
        .xi_valid(xi_valid), .xi_last(xi_last), .xi(xi), .mod_idx(mod_idx),
        .corr(corr), .fault(fault)
    );

    // behavioural reference
    logic [127:0] m_acc, m_sum;
    bit m_run, m_chk, m_corr, m_fault;
    bit p_v, p_l;
    logic [127:0] p_x, p_i;
    localparam logic [127:0] ONE = 128'd1 << FW;

    function automatic logic [127:0] est(input logic [127:0] x, input logic [127:0] i);
        return (x << (FW - R)) + ((x * (2 * i + 1)) << (FW - 2 * R));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_run = 0; m_chk = 0; m_corr = 0; m_fault = 0;
            p_v = 0; p_l = 0; p_x = 0; p_i = 0;
        end else begin
            m_corr = 0;
            if (start) begin
                m_acc = ONE >> (SIGMA + 1); m_run = 1; m_chk = check_en; m_fault = 0;
            end else if (m_run && p_v) begin
                m_sum = m_acc + est(p_x, p_i);
                m_corr = (m_sum >= ONE);
                m_acc = m_sum % ONE;
                if (p_l) begin
                    m_run = 0;
                    if (m_chk && (m_acc >> (FW - SIGMA)) != 0) m_fault = 1;
                end
            end
            p_v = xi_valid; p_l = xi_last; p_x = 128'(xi); p_i = 128'(mod_idx);
        end
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_on) begin
            check("R4 corr vs model (R2 term)", 128'(corr), 128'(m_corr));
            check("R6 fault vs model", 128'(fault), 128'(m_fault));
        end
    end

    task automatic drive(input bit st, input bit ce, input bit v, input logic [R-1:0] x,
                         input int i, input bit l);
        start = st; check_en = ce; xi_valid = v; xi = x; mod_idx = IW'(i); xi_last = l;
        @(negedge clk);
    endtask

    task automatic idle(); drive(0, 0, 0, '0, 0, 0); endtask

    localparam logic [R-1:0] XMAX = '1;

    initial begin
        repeat (4) @(negedge clk);
        check("R1 corr after reset", 128'(corr), 0);
        check("R1 fault after reset", 128'(fault), 0);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1;

        // R1/R5: terms before any start are ignored
        drive(0, 0, 1, XMAX, 15, 0); drive(0, 0, 1, XMAX, 15, 1); idle();
        check("R5 idle term no corr", 128'(corr), 0);

        // R2: multiplier term alone makes the crossing; small residue, no fault
        drive(1, 1, 0, '0, 0, 0);
        drive(0, 0, 1, XMAX, 0, 1); idle();
        check("R2 series term crosses 1.0", 128'(corr), 1);
        check("R6 residue in bias, no fault", 128'(fault), 0);

        // R4: two half-scale terms, second crosses
        drive(1, 1, 0, '0, 0, 0);
        drive(0, 0, 1, R'(64'h8_0000_0000), 0, 0);
        drive(0, 0, 1, R'(64'h8_0000_0000), 0, 0);
        check("R4 first term no corr", 128'(corr), 0);
        drive(0, 0, 1, '0, 3, 1);
        check("R4 second term corr", 128'(corr), 1);
        idle();
        check("R6 residue in window sets fault", 128'(fault), 1);
        check("R4 zero term no corr", 128'(corr), 0);

        // R8 and R5: fault holds through idle terms
        drive(0, 0, 1, XMAX, 7, 1); idle(); idle();
        check("R8 fault sticky", 128'(fault), 1);
        check("R5 idle term no corr", 128'(corr), 0);

        // R3: start clears fault
        drive(1, 1, 0, '0, 0, 0);
        check("R3 start clears fault", 128'(fault), 0);
        drive(0, 0, 1, '0, 5, 1); idle();
        check("R3 bias alone passes check", 128'(fault), 0);

        // R10: corr and fault same cycle
        drive(1, 1, 0, '0, 0, 0);
        drive(0, 0, 1, XMAX, 15, 1); idle();
        check("R10 corr", 128'(corr), 1);
        check("R10 fault", 128'(fault), 1);

        // R7: same term, check off
        drive(1, 0, 0, '0, 0, 0);
        drive(0, 0, 1, XMAX, 15, 1); idle();
        check("R7 corr", 128'(corr), 1);
        check("R7 no fault", 128'(fault), 0);

        // R9: start collides with pending addition
        drive(1, 1, 0, '0, 0, 0);
        drive(0, 0, 1, XMAX, 15, 0);
        drive(1, 1, 0, '0, 0, 0);
        check("R9 dropped term no corr", 128'(corr), 0);
        drive(0, 0, 1, '0, 0, 1); idle();
        check("R9 fraction reloaded", 128'(fault), 0);

        // random traffic against the model
        for (int c = 0; c < 4000; c++) begin
            bit st, ce, v, l;
            logic [R-1:0] x;
            st = ($urandom_range(0, 39) == 0);
            ce = $urandom_range(0, 1);
            v  = ($urandom_range(0, 9) < 7);
            l  = ($urandom_range(0, 7) == 0);
            x  = ($urandom_range(0, 3) == 0) ? '0 : R'({$urandom, $urandom});
            drive(st, ce, v, x, $urandom_range(0, N - 1), l);
        end
        idle(); idle();

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 run did not end actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule